// File: doc/BRIEF.md
# Floating-Point Pipeline Hazard Interlock

This block is the issue control for an in-order pipeline. Instructions pass through fetch and decode, then through one of three execution paths, then a memory stage and a write-back stage. The three paths are a four-stage floating-point adder, a seven-stage floating-point multiplier and a single address stage for loads. Each cycle the block reads the instruction waiting in decode: its operation class, its two source register numbers and its destination. It keeps a record, one entry per cycle of age, of every instruction that has left decode and will write a register. From that record it decides whether the decode instruction must wait. When the instruction can go, it also tells the operand multiplexers where each source value comes from.

Stalls cover three cases. The first is a read-after-write dependence whose value cannot yet be delivered. The second is a write whose write-back would not be the last to reach its register. The third is a write whose write-back would fall in the same cycle as an earlier write, because there is only one write-back port. A configuration input selects one of two modes. With bypassing on, results go straight from the end of a unit to the consumer's first execute stage. With bypassing off, consumers wait for the register file. The register file writes in the first half of a cycle and reads in the second half, so a value being written back can be read in decode in that same cycle.

While `stall` is high, the surrounding pipeline holds fetch and decode and puts a bubble into the first execute stage. The block records the held instruction only on the cycle it actually issues.

Top module: `fp_hazard_ctl`

## Requirements
- R1: After reset, and after any reset in mid-run, nothing is tracked. The first decode instruction sees `stall`=0, and both select outputs are 0.
- R2: None of the following creates a dependence. A source of register 0. A producer with `dec_dst_vld`=0 or destination 0. A producer of class 3, which does not write. Class encoding: 0 = add, 1 = multiply, 2 = load, 3 = non-writing.
- R3: With `fwd_en`=0, a consumer that appears d cycles after its producer issued (d=1 means adjacent) stalls until d reaches 6 for an add, 9 for a multiply and 3 for a load. Both selects stay at 0, which means register file.
- R4: With `fwd_en`=1 and an add producer, the consumer stalls while d≤3. At d=4 the select is 1, the adder result. At d=5 the select is 3, the write-back latch. From d=6 on the select is 0.
- R5: With `fwd_en`=1 and a multiply producer, the consumer stalls while d≤6. At d=7 the select is 2, the multiplier result. At d=8 the select is 3. From d=9 on the select is 0.
- R6: With `fwd_en`=1 and a load producer, the consumer stalls exactly one cycle when d=1. At d=2 the select is 3. From d=3 on the select is 0.
- R7: When several tracked producers write the same register, the youngest one alone decides the stall and the select.
- R8: `fwd_sel1` follows source 1 and `fwd_sel2` follows source 2, each on its own. The instruction issues only when both are satisfied.
- R9: A writing instruction stalls if its write-back would land in the same cycle as that of a tracked writer, whatever the registers.
- R10: A writing instruction stalls while a tracked writer to the same register would write back in the same cycle or later.
- R11: With `dec_valid`=0, `stall` is 0. While `stall` is 1, both selects read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwd_en | input | 1 | 1 = bypass mode, 0 = wait for register file |
| dec_valid | input | 1 | Decode stage holds an instruction |
| dec_op | input | 2 | Class: 0 add, 1 multiply, 2 load, 3 non-writing |
| dec_src1 | input | AW | First source register |
| dec_src2 | input | AW | Second source register |
| dec_dst | input | AW | Destination register |
| dec_dst_vld | input | 1 | Destination field is meaningful |
| stall | output | 1 | Hold fetch and decode, bubble into execute |
| fwd_sel1 | output | 2 | Source 1: 0 register file, 1 adder, 2 multiplier, 3 write-back latch |
| fwd_sel2 | output | 2 | Source 2, same encoding |

## Verification
The hardest situations to reach are those where two tracked instructions interact at one exact age. Examples are an old multiply and a younger add to the same register, a multiply and a load whose results are both ready in the same cycle, and an add whose write-back would collide with a multiply issued three cycles earlier. The bench reaches these by placing non-writing filler instructions between producers, so that each gap in cycles is set exactly. Every producer class is swept against every distance from 1 to 10, in both modes and on both operands, and the stall count and select are worked out from the latency rules alone.

// File: rtl/fp_hazard_ctl.sv
module fp_hazard_ctl #(
  parameter int AW      = 5,
  parameter int ADD_LAT = 4,
  parameter int MUL_LAT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwd_en,
  input  logic          dec_valid,
  input  logic [1:0]    dec_op,
  input  logic [AW-1:0] dec_src1,
  input  logic [AW-1:0] dec_src2,
  input  logic [AW-1:0] dec_dst,
  input  logic          dec_dst_vld,
  output logic          stall,
  output logic [1:0]    fwd_sel1,
  output logic [1:0]    fwd_sel2
);
  localparam int NS = MUL_LAT + 2;
  localparam logic [1:0] OP_ADD = 2'd0, OP_MUL = 2'd1, OP_NW = 2'd3;
  localparam logic [1:0] SEL_RF = 2'd0, SEL_ADD = 2'd1, SEL_MUL = 2'd2, SEL_WB = 2'd3;

  logic [NS-1:0] age_v;
  logic [AW-1:0] age_d [NS];
  logic [1:0]    age_op [NS];
  logic          wr_new, wr_stall;

  function automatic int wb_at(input logic [1:0] op);
    case (op)
      OP_ADD:  return ADD_LAT + 1;
      OP_MUL:  return MUL_LAT + 1;
      default: return 2;
    endcase
  endfunction

  function automatic int ready_at(input logic [1:0] op);
    case (op)
      OP_ADD:  return ADD_LAT - 1;
      OP_MUL:  return MUL_LAT - 1;
      default: return 1;
    endcase
  endfunction

  function automatic logic [1:0] unit_sel(input logic [1:0] op);
    case (op)
      OP_ADD:  return SEL_ADD;
      OP_MUL:  return SEL_MUL;
      default: return SEL_WB;
    endcase
  endfunction

  assign wr_new = dec_valid && dec_dst_vld && dec_dst != '0 && dec_op != OP_NW;

  for (genvar g = 0; g < 2; g++) begin : g_src
    logic [AW-1:0] src;
    logic          st;
    logic [1:0]    sl;
    assign src = (g == 0) ? dec_src1 : dec_src2;
    always_comb begin
      st = 1'b0;
      sl = SEL_RF;
      for (int k = NS - 1; k >= 0; k--) begin
        if (age_v[k] && age_d[k] == src && src != '0 && k < wb_at(age_op[k])) begin
          if (!fwd_en || k < ready_at(age_op[k])) begin
            st = 1'b1;
            sl = SEL_RF;
          end else begin
            st = 1'b0;
            sl = (k == ready_at(age_op[k])) ? unit_sel(age_op[k]) : SEL_WB;
          end
        end
      end
    end
  end

  always_comb begin
    wr_stall = 1'b0;
    if (wr_new)
      for (int k = 0; k < NS; k++)
        if (age_v[k]) begin
          if (wb_at(age_op[k]) - k == wb_at(dec_op) + 1) wr_stall = 1'b1;
          if (age_d[k] == dec_dst && wb_at(age_op[k]) - k >= wb_at(dec_op) + 1) wr_stall = 1'b1;
        end
  end

  assign stall    = dec_valid && (g_src[0].st || g_src[1].st || wr_stall);
  assign fwd_sel1 = (dec_valid && !stall) ? g_src[0].sl : SEL_RF;
  assign fwd_sel2 = (dec_valid && !stall) ? g_src[1].sl : SEL_RF;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age_v <= '0;
    else        age_v <= {age_v[NS-2:0], wr_new && !stall};

  always_ff @(posedge clk) begin
    age_d[0]  <= dec_dst;
    age_op[0] <= dec_op;
    for (int k = 1; k < NS; k++) begin
      age_d[k]  <= age_d[k-1];
      age_op[k] <= age_op[k-1];
    end
  end

  AST_RESET_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !stall); // R1
  AST_ZERO_SRC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_src1 == '0 && dec_src2 == '0 && !wr_new) |-> !stall); // R2
  AST_ADJ_RAW_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_new && !stall) && dec_valid &&
     (dec_src1 == $past(dec_dst) || dec_src2 == $past(dec_dst))) |-> stall); // R4
  AST_WAW_MUL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_new && !stall && dec_op == OP_MUL) && wr_new &&
     dec_op != OP_MUL && dec_dst == $past(dec_dst)) |-> stall); // R10
endmodule

// File: tb/fp_hazard_ctl_test.sv
module fp_hazard_ctl_test;
  logic clk = 1'b0, rst_n = 1'b0, fwd_en = 1'b1, dec_valid = 1'b0, dec_dst_vld = 1'b0;
  logic [1:0] dec_op = 2'd3;
  logic [4:0] dec_src1 = '0, dec_src2 = '0, dec_dst = '0;
  logic stall;
  logic [1:0] fwd_sel1, fwd_sel2;
  int vectors = 0, miscompares = 0;

  always #10 clk = ~clk;

  fp_hazard_ctl uut (.clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .dec_valid(dec_valid),
    .dec_op(dec_op), .dec_src1(dec_src1), .dec_src2(dec_src2), .dec_dst(dec_dst),
    .dec_dst_vld(dec_dst_vld), .stall(stall), .fwd_sel1(fwd_sel1), .fwd_sel2(fwd_sel2));

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic present(input logic [1:0] op, input logic [4:0] s1, input logic [4:0] s2,
                         input logic [4:0] d, input logic dv,
                         output int nst, output logic [1:0] o1, output logic [1:0] o2);
    dec_valid = 1'b1; dec_op = op; dec_src1 = s1; dec_src2 = s2; dec_dst = d; dec_dst_vld = dv;
    #1;
    nst = 0;
    while (stall && nst < 40) begin
      if (fwd_sel1 != 2'd0 || fwd_sel2 != 2'd0) check("R11 sel during stall", 1, 0);
      nst++;
      @(negedge clk); #1;
    end
    o1 = fwd_sel1; o2 = fwd_sel2;
    @(negedge clk);
    dec_valid = 1'b0; dec_src1 = '0; dec_src2 = '0; dec_dst = '0; dec_dst_vld = 1'b0; dec_op = 2'd3;
  endtask

  task automatic idle(input int n);
    dec_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic int wbs(input int op);
    return (op == 0) ? 5 : (op == 1) ? 8 : 2;
  endfunction
  function automatic int rdys(input int op);
    return (op == 0) ? 3 : (op == 1) ? 6 : 1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int n;
    logic [1:0] a, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    present(2'd3, 5'd5, 5'd6, 5'd0, 1'b0, n, a, b);
    check("R1 stall after reset", n, 0);
    check("R1 sel after reset", int'(a) + int'(b), 0);

    present(2'd1, 5'd0, 5'd0, 5'd5, 1'b1, n, a, b);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    present(2'd3, 5'd5, 5'd0, 5'd0, 1'b0, n, a, b);
    check("R1 mid-run reset clears", n, 0);
    idle(12);

    present(2'd0, 5'd0, 5'd0, 5'd5, 1'b0, n, a, b);
    present(2'd3, 5'd5, 5'd0, 5'd0, 1'b0, n, a, b);
    check("R2 invalid dst", n, 0);
    present(2'd3, 5'd0, 5'd0, 5'd5, 1'b1, n, a, b);
    present(2'd3, 5'd5, 5'd0, 5'd0, 1'b0, n, a, b);
    check("R2 non-writing op", n, 0);
    present(2'd0, 5'd0, 5'd0, 5'd0, 1'b1, n, a, b);
    present(2'd3, 5'd0, 5'd0, 5'd0, 1'b0, n, a, b);
    check("R2 register zero", n, 0);
    idle(12);

    for (int op = 0; op < 3; op++)
      for (int f = 0; f < 2; f++)
        for (int d = 1; d <= 10; d++)
          for (int s = 0; s < 2; s++) begin
            int need, est, k, esel;
            string tag;
            fwd_en = f[0];
            tag = (f == 0) ? "R3" : (op == 0) ? "R4" : (op == 1) ? "R5" : "R6";
            present(op[1:0], 5'd0, 5'd0, 5'd5, 1'b1, n, a, b);
            for (int j = 1; j < d; j++) present(2'd3, 5'd0, 5'd0, 5'd0, 1'b0, n, a, b);
            present(2'd3, (s == 0) ? 5'd5 : 5'd0, (s == 1) ? 5'd5 : 5'd0, 5'd0, 1'b0, n, a, b);
            need = (f == 1) ? rdys(op) + 1 : wbs(op) + 1;
            est  = (need > d) ? need - d : 0;
            k    = d + est - 1;
            esel = 0;
            if (f == 1) begin
              if (k == rdys(op)) esel = (op == 2) ? 3 : op + 1;
              else if (k == wbs(op) - 1) esel = 3;
            end
            check({tag, " stall count"}, n, est);
            check({tag, " select"}, (s == 0) ? int'(a) : int'(b), esel);
            idle(12);
          end

    fwd_en = 1'b1;
    present(2'd1, 5'd0, 5'd0, 5'd5, 1'b1, n, a, b);
    for (int j = 0; j < 3; j++) present(2'd3, 5'd0, 5'd0, 5'd0, 1'b0, n, a, b);
    present(2'd0, 5'd0, 5'd0, 5'd5, 1'b1, n, a, b);
    check("R10 later add same dst free", n, 0);
    present(2'd3, 5'd5, 5'd0, 5'd0, 1'b0, n, a, b);
    check("R7 youngest stall", n, 3);
    check("R7 youngest select", int'(a), 1);
    idle(12);

    present(2'd1, 5'd0, 5'd0, 5'd6, 1'b1, n, a, b);
    for (int j = 0; j < 4; j++) present(2'd3, 5'd0, 5'd0, 5'd0, 1'b0, n, a, b);
    present(2'd2, 5'd0, 5'd0, 5'd5, 1'b1, n, a, b);
    present(2'd3, 5'd6, 5'd5, 5'd0, 1'b0, n, a, b);
    check("R8 stall both", n, 1);
    check("R8 sel1 multiplier", int'(a), 2);
    check("R8 sel2 load", int'(b), 3);
    idle(12);

    present(2'd1, 5'd0, 5'd0, 5'd5, 1'b1, n, a, b);
    for (int j = 0; j < 2; j++) present(2'd3, 5'd0, 5'd0, 5'd0, 1'b0, n, a, b);
    present(2'd0, 5'd0, 5'd0, 5'd6, 1'b1, n, a, b);
    check("R9 write-back port clash", n, 1);
    idle(12);

    present(2'd1, 5'd0, 5'd0, 5'd5, 1'b1, n, a, b);
    present(2'd0, 5'd0, 5'd0, 5'd5, 1'b1, n, a, b);
    check("R10 WAW hold", n, 3);
    idle(12);

    present(2'd0, 5'd0, 5'd0, 5'd5, 1'b1, n, a, b);
    dec_valid = 1'b0; dec_src1 = 5'd5; dec_src2 = 5'd5; #1;
    check("R11 no stall without valid", int'(stall), 0);
    @(negedge clk);
    idle(12);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule